// File: doc/BRIEF.md
# Next-interrupt identifier resolver

This block sits behind an interrupt controller and turns three pending words into the single interrupt a handler should serve next. The words are a basic word, which holds eight directly mapped sources, a set of shortcut flags and two bank summary flags, and the two full 32-bit pending words of peripheral banks 1 and 2. The handler raises a request. One cycle later the block presents a registered identifier together with a valid flag. The handler serves that source, clears it upstream, and asks again until the valid flag comes back low.

The search is not a flat priority encoder. The eight basic sources are checked first. The shortcut flags come next. Each shortcut flag stands for one specific source in bank 1 or bank 2, and a fixed table maps it back to that source's true bank and bit. The bank summaries come last, and they are resolved by searching the full pending word of the bank they name. The identifier is the bank number in bits 6:5 and the bit index in bits 4:0. The all-ones code 7'h7F means nothing is pending.

A small controller with three states sequences the answers. `S_EMPTY` holds after reset until the first request. `S_ANSWER` is the cycle in which a fresh answer is presented and `ack_o` is high. `S_HOLD` keeps that answer for as long as no new request arrives. The transitions are:
- any state with `req_i` high goes to `S_ANSWER`;
- `S_ANSWER` without a request goes to `S_HOLD`;
- `S_HOLD` and `S_EMPTY` without a request stay where they are.

Top module: `irq_next_id`

## Requirements
- R1: After reset, `ack_o` is 0, `valid_o` is 0 and `id_o` is 7'h7F.
- R2: A request sampled at a clock edge produces `ack_o` high for exactly the following cycle. `ack_o` is never high in a cycle that does not follow a request, and back-to-back requests are each answered.
- R3: Without a request, `id_o` and `valid_o` keep their values even when the pending inputs change.
- R4: When no source is pending after masking, the answer is `id_o` = 7'h7F with `valid_o` = 0. Otherwise `valid_o` is 1 and `id_o` is never 7'h7F.
- R5: The basic bits 7:0 have top priority. The lowest set bit among them wins and gives bank 0, that bit index.
- R6: Bits 31:21 of the basic word are ignored. Only bits 20:0 take part.
- R7: If no basic bit is set, the lowest set basic bit in 14:10 wins. It maps to bank 1 as follows: bit 10 to source 7, bit 11 to 9, bit 12 to 10, bit 13 to 18, and bit 14 to 19.
- R8: Next in line, the lowest set basic bit in 20:15 wins. It maps to bank 2 as follows: bit 15 to source 21, bit 16 to 22, bit 17 to 23, bit 18 to 24, bit 19 to 25, and bit 20 to 30.
- R9: Any shortcut flag takes precedence over both bank summaries. The bank-1 shortcut group (14:10) takes precedence over the bank-2 group (20:15).
- R10: With no basic or shortcut bit set, basic bit 8 selects the lowest set bit of the bank-1 word, giving bank 1. Failing that, basic bit 9 selects the lowest set bit of the bank-2 word, giving bank 2.
- R11: A summary bit whose bank word is all zero is treated as not pending.
- R12: Each answer is computed from the pending inputs sampled at the request edge, so a source cleared before a request is not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request for the next identifier |
| basic_pend_i | input | 32 | Basic pending word (sources, shortcut flags, summaries) |
| bank1_pend_i | input | 32 | Bank-1 full pending word |
| bank2_pend_i | input | 32 | Bank-2 full pending word |
| ack_o | output | 1 | High for one cycle when a fresh answer is presented |
| valid_o | output | 1 | Answer names a pending source |
| id_o | output | 7 | Identifier: bank in 6:5, bit in 4:0; 7'h7F when none |

## Verification
A fault in the priority chain or in the shortcut table shows up in the `id_o` that follows the very next request, as a wrong bank or a wrong true bit. The stimulus therefore sets bits from several groups at once, so that each precedence boundary is exercised. A controller stuck in the wrong state shows up within one cycle as a missing, doubled or spurious `ack_o`, or as an answer that drifts while no request is made. A mishandled empty bank summary shows up as a bank-0 or bank-3 code, or as a valid flag paired with 7'h7F.

// File: rtl/irq_next_id_pkg.sv
package irq_next_id_pkg;

    localparam int WORD_W    = 32;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int BANK_W    = 2;
    localparam int ID_W      = BANK_W + BIT_W;
    localparam int BASIC_N   = 8;
    localparam int SUM1_POS  = 8;
    localparam int SUM2_POS  = 9;
    localparam int SC1_LO    = 10;
    localparam int SC1_N     = 5;
    localparam int SC2_LO    = SC1_LO + SC1_N;
    localparam int SC2_N     = 6;
    localparam int VALID_TOP = SC2_LO + SC2_N;
    localparam logic [WORD_W-1:0] BASIC_KEEP = WORD_W'((64'd1 << VALID_TOP) - 64'd1);
    localparam logic [ID_W-1:0]   NONE_ID    = '1;

    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_ANSWER = 2'd1,
        S_HOLD   = 2'd2
    } ans_state_e;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [BIT_W-1:0]  bitn;
    } pick_t;

    // Map a shortcut index within its group back to the true source bit.
    function automatic logic [BIT_W-1:0] shortcut_src(input logic second, input logic [2:0] k);
        logic [BIT_W-1:0] r;
        r = '0;
        if (!second) begin
            unique case (k)
                3'd0:    r = BIT_W'(7);
                3'd1:    r = BIT_W'(9);
                3'd2:    r = BIT_W'(10);
                3'd3:    r = BIT_W'(18);
                default: r = BIT_W'(19);
            endcase
        end else begin
            unique case (k)
                3'd0:    r = BIT_W'(21);
                3'd1:    r = BIT_W'(22);
                3'd2:    r = BIT_W'(23);
                3'd3:    r = BIT_W'(24);
                3'd4:    r = BIT_W'(25);
                default: r = BIT_W'(30);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_low_bit.sv
module irq_low_bit #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        // scan downwards so the lowest set index is the last one written
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_next_id_pkg::*;
(
    input  logic [WORD_W-1:0] basic_i,
    input  logic [WORD_W-1:0] bank1_i,
    input  logic [WORD_W-1:0] bank2_i,
    output pick_t             pick_o
);
    logic [WORD_W-1:0] basic_m;
    assign basic_m = basic_i & BASIC_KEEP;

    localparam int BI_W  = $clog2(BASIC_N);
    localparam int S1I_W = $clog2(SC1_N);
    localparam int S2I_W = $clog2(SC2_N);

    logic             b_hit, s1_hit, s2_hit;
    logic [BI_W-1:0]  b_idx;
    logic [S1I_W-1:0] s1_idx;
    logic [S2I_W-1:0] s2_idx;

    irq_low_bit #(.W(BASIC_N)) u_basic (
        .vec_i(basic_m[BASIC_N-1:0]), .hit_o(b_hit), .idx_o(b_idx));
    irq_low_bit #(.W(SC1_N)) u_sc1 (
        .vec_i(basic_m[SC1_LO +: SC1_N]), .hit_o(s1_hit), .idx_o(s1_idx));
    irq_low_bit #(.W(SC2_N)) u_sc2 (
        .vec_i(basic_m[SC2_LO +: SC2_N]), .hit_o(s2_hit), .idx_o(s2_idx));

    // one full-word search per peripheral bank
    logic [1:0]             w_hit;
    logic [1:0][BIT_W-1:0]  w_idx;
    logic [1:0][WORD_W-1:0] w_vec;
    assign w_vec[0] = bank1_i;
    assign w_vec[1] = bank2_i;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        irq_low_bit #(.W(WORD_W)) u_word (
            .vec_i(w_vec[g]), .hit_o(w_hit[g]), .idx_o(w_idx[g]));
    end

    logic sum1, sum2;
    assign sum1 = basic_m[SUM1_POS] && w_hit[0];   // R11: empty bank word ignored
    assign sum2 = basic_m[SUM2_POS] && w_hit[1];

    always_comb begin
        pick_o = '{hit: 1'b0, bank: '1, bitn: '1};
        if (b_hit) begin                               // R5
            pick_o = '{hit: 1'b1, bank: 2'd0, bitn: BIT_W'(b_idx)};
        end else if (s1_hit) begin                     // R7, R9
            pick_o = '{hit: 1'b1, bank: 2'd1, bitn: shortcut_src(1'b0, 3'(s1_idx))};
        end else if (s2_hit) begin                     // R8
            pick_o = '{hit: 1'b1, bank: 2'd2, bitn: shortcut_src(1'b1, 3'(s2_idx))};
        end else if (sum1) begin                       // R10
            pick_o = '{hit: 1'b1, bank: 2'd1, bitn: w_idx[0]};
        end else if (sum2) begin
            pick_o = '{hit: 1'b1, bank: 2'd2, bitn: w_idx[1]};
        end
    end
endmodule

// File: rtl/irq_next_id.sv
module irq_next_id
    import irq_next_id_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [WORD_W-1:0] basic_pend_i,
    input  logic [WORD_W-1:0] bank1_pend_i,
    input  logic [WORD_W-1:0] bank2_pend_i,
    output logic              ack_o,
    output logic              valid_o,
    output logic [ID_W-1:0]   id_o
);
    pick_t pick;

    irq_pick u_pick (
        .basic_i(basic_pend_i),
        .bank1_i(bank1_pend_i),
        .bank2_i(bank2_pend_i),
        .pick_o (pick)
    );

    ans_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY:  state_d = req_i ? S_ANSWER : S_EMPTY;
            S_ANSWER: state_d = req_i ? S_ANSWER : S_HOLD;
            S_HOLD:   state_d = req_i ? S_ANSWER : S_HOLD;
            default:  state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= S_EMPTY;
        else         state_q <= state_d;
    end

    // answer registers: loaded only on a request (R3, R12)
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            id_o    <= NONE_ID;
        end else if (req_i) begin
            valid_o <= pick.hit;
            id_o    <= pick.hit ? {pick.bank, pick.bitn} : NONE_ID;
        end
    end

    assign ack_o = (state_q == S_ANSWER);

    // R2: every request is answered in the next cycle
    a_r2_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> ack_o);
    // R2: no answer strobe without a request
    a_r2_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !ack_o);
    // R3: answer held between requests
    a_r3_hold_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> ($stable(id_o) && $stable(valid_o)));
    // R4: the none code and the valid flag agree
    a_r4_none_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o == (id_o != NONE_ID)));
    // R5: a basic source wins whenever one is set
    a_r5_basic_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && (|basic_pend_i[BASIC_N-1:0])) |=> (valid_o && id_o[ID_W-1 -: BANK_W] == 2'd0));
    // R11: a valid answer never names a nonexistent bank
    a_r11_bank_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (id_o[ID_W-1 -: BANK_W] != 2'd3));
endmodule

// File: tb/irq_next_id_test.sv
module irq_next_id_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] p0 = '0, p1 = '0, p2 = '0;
    logic        ack, valid;
    logic [6:0]  id;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_next_id uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req),
        .basic_pend_i(p0), .bank1_pend_i(p1), .bank2_pend_i(p2),
        .ack_o(ack), .valid_o(valid), .id_o(id)
    );

    typedef struct packed {
        logic [31:0] b0;
        logic [31:0] b1;
        logic [31:0] b2;
        logic [6:0]  eid;
        logic        ev;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{32'h0, 32'h0, 32'h0, 7'h7F, 1'b0, 8'd4},                 // R4 nothing
        '{32'h24, 32'h0, 32'h0, 7'h02, 1'b1, 8'd5},                // R5 lowest basic
        '{32'h480, 32'h1, 32'h0, 7'h07, 1'b1, 8'd5},               // R5 over shortcut
        '{32'h1000, 32'h0, 32'h0, 7'h2A, 1'b1, 8'd7},              // R7 bit12 -> b1:10
        '{32'h4000, 32'h0, 32'h0, 7'h33, 1'b1, 8'd7},              // R7 bit14 -> b1:19
        '{32'h100000, 32'h0, 32'h0, 7'h5E, 1'b1, 8'd8},            // R8 bit20 -> b2:30
        '{32'h18000, 32'h0, 32'h0, 7'h55, 1'b1, 8'd8},             // R8 bit15 -> b2:21
        '{32'h8400, 32'h0, 32'h0, 7'h27, 1'b1, 8'd9},              // R9 group order
        '{32'h500, 32'h1, 32'h0, 7'h27, 1'b1, 8'd9},               // R9 over summary
        '{32'h300, 32'h110, 32'h1, 7'h24, 1'b1, 8'd10},            // R10 bank1 first
        '{32'h200, 32'h0, 32'h80000000, 7'h5F, 1'b1, 8'd10},       // R10 bank2
        '{32'hFFE00000, 32'hFFFFFFFF, 32'h0, 7'h7F, 1'b0, 8'd6},   // R6 high bits
        '{32'h100, 32'h0, 32'h0, 7'h7F, 1'b0, 8'd11},              // R11 empty word
        '{32'h300, 32'h0, 32'h4, 7'h42, 1'b1, 8'd11}               // R11 fall through
    };

    task automatic check(input logic [6:0] eid, input logic ev, input logic eack, input string tag);
        tests++;
        if (id !== eid || valid !== ev || ack !== eack) begin
            fails++;
            $display("FAIL %s: id=%h valid=%b ack=%b, expected id=%h valid=%b ack=%b",
                     tag, id, valid, ack, eid, ev, eack);
        end
    endtask

    // drive pending + request at a falling edge; result visible one edge later
    task automatic ask(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        p0 = a; p1 = b; p2 = c; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(7'h7F, 1'b0, 1'b0, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            ask(VT[i].b0, VT[i].b1, VT[i].b2);
            check(VT[i].eid, VT[i].ev, 1'b1, $sformatf("R%0d vector %0d", VT[i].rq, i));
        end

        // R3: hold while inputs change with no request; R2 no extra ack
        ask(32'h8, 32'h0, 32'h0);
        check(7'h03, 1'b1, 1'b1, "R5 bit3");
        @(negedge clk);
        p0 = 32'h1; p1 = 32'h2;
        @(negedge clk);
        check(7'h03, 1'b1, 1'b0, "R3 hold / R2 single ack");

        // R12: clear the source upstream, ask again
        ask(32'h0, 32'h0, 32'h0);
        check(7'h7F, 1'b0, 1'b1, "R12 cleared source gone");

        // R2: back-to-back requests, each answered with fresh state
        @(negedge clk);
        p0 = 32'h2000; req = 1'b1;               // bit13 -> bank1 18
        @(negedge clk);
        check(7'h32, 1'b1, 1'b1, "R2 first of pair");
        p0 = 32'h40000;                           // bit18 -> bank2 24
        @(negedge clk);
        req = 1'b0;
        check(7'h58, 1'b1, 1'b1, "R2 second of pair");
        @(negedge clk);
        check(7'h58, 1'b0 | 1'b1, 1'b0, "R2 ack drops");

        // R1: reset mid-operation restores the reset state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(7'h7F, 1'b0, 1'b0, "R1 re-reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule